// File: doc/BRIEF.md
# Per-Endpoint Control Message Queue Root

This block is the root node of a tree-shaped control-message bus. Up to sixteen endpoints send short packets to the root, and the root sends packets back to each of them. Every endpoint owns one receive queue and one transmit queue inside the root. Both queue sets sit in simple dual-port memories: the bus side writes received words and reads words to transmit, and a user processor reads received words and writes words to transmit through its own address port.

A queue is a fixed circular region. The user learns where to read or write from a set of status registers, selected by queue number, and hands space back or hands packets over by writing word counts to a single control port. A receive commit frees consumed words. A transmit commit tells the root to send exactly that many words, starting at the oldest unsent position, as one packet to the endpoint that owns the queue. When several transmit queues have committed packets, they are served in round-robin order.

Top module: `cmsg_root`

## Requirements
- R1: After reset every receive queue reports count 0 with start and end 0, every transmit queue reports start 0, free 64 and not busy, `tx_valid` is low and `rx_ready` is high.
- R2: A word accepted on the receive bus (`rx_valid` and `rx_ready` high at a clock edge) is stored in the queue named by `rx_src` at that queue's write position; the user read address is {queue number in bits 9:6, word offset in bits 5:0}, and `usr_rd_data` holds the word one cycle after `usr_rd_en`.
- R3: A receive queue's reported start pointer and item count change only when a word marked `rx_eop` is accepted; words of an unfinished packet are not counted.
- R4: `rx_ready` is low while the queue named by `rx_src` holds 64 unconsumed words (complete or partial), so no word is dropped, and it rises again once words are consumed.
- R5: A control write with `ctl_kind`=0 and a count not above the queue's item count advances that queue's end pointer by the count and lowers its item count; a larger count is ignored.
- R6: All queue pointers wrap modulo 64, so a queue's storage is reused from offset 0 after offset 63.
- R7: A control write with `ctl_kind`=1 is accepted only when the count is 1 to the queue's free space and that queue has no packet awaiting transmission; it then advances the transmit start pointer by the count and marks the queue busy, otherwise it is ignored.
- R8: An accepted transmit commit produces one packet of exactly the committed number of words read from the queue starting at its oldest unsent position, with `tx_dst` equal to the queue number, `tx_sop` on the first word and `tx_eop` on the last.
- R9: While `tx_valid` is high and `tx_ready` is low, every transmit output holds its value.
- R10: A transmit queue's free space and busy flag are restored only after its last word has been accepted by the bus.
- R11: Pending transmit queues are served round-robin, starting from the queue after the one last served; after reset queue 0 has first turn.
- R12: Status outputs are registered and describe the queue selected by `stat_sel` as it stood at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive word present |
| rx_eop | input | 1 | Receive word is last of its packet |
| rx_src | input | 4 | Sending endpoint number |
| rx_data | input | 16 | Receive word |
| rx_ready | output | 1 | Root can take the word for `rx_src` |
| tx_valid | output | 1 | Transmit word present |
| tx_sop | output | 1 | First word of transmit packet |
| tx_eop | output | 1 | Last word of transmit packet |
| tx_dst | output | 4 | Target endpoint number |
| tx_data | output | 16 | Transmit word |
| tx_ready | input | 1 | Bus accepts the transmit word |
| usr_rd_en | input | 1 | User read of receive memory |
| usr_rd_addr | input | 10 | {queue, offset} read address |
| usr_rd_data | output | 16 | Read data, one cycle latency |
| usr_wr_en | input | 1 | User write of transmit memory |
| usr_wr_addr | input | 10 | {queue, offset} write address |
| usr_wr_data | input | 16 | Write data |
| ctl_we | input | 1 | Control write strobe |
| ctl_kind | input | 1 | 0 = receive consume, 1 = transmit commit |
| ctl_q | input | 4 | Queue number for the control write |
| ctl_cnt | input | 7 | Word count for the control write |
| stat_sel | input | 4 | Queue whose status is reported |
| stat_rx_start | output | 6 | Receive start (next packet) pointer |
| stat_rx_end | output | 6 | Receive end (oldest unread) pointer |
| stat_rx_count | output | 7 | Complete received words not consumed |
| stat_tx_start | output | 6 | Transmit start pointer (next write position) |
| stat_tx_free | output | 7 | Free transmit words |
| stat_tx_busy | output | 1 | A committed packet awaits transmission |

## Verification
The bench fills one receive queue to exactly 64 words and probes `rx_ready` for that source and a neighbour; a design that compared against 63 or ignored the unconsumed region would stall early or overwrite unread words. It then crosses the 64-word boundary in both directions, where a pointer that did not wrap would read stale words or report a wrong start. Consume and commit counts that are zero, too large or aimed at a busy queue must leave the status untouched, and a held transmit word is watched for drift while `tx_ready` is low. Three queues are made pending behind a stalled packet so that round-robin order (7, 9, 2) differs from fixed priority, which a priority encoder would send as 7, 2, 9.

// File: rtl/cmsg_pkg.sv
package cmsg_pkg;
  typedef enum logic {
    CTL_RX_CONSUME = 1'b0,
    CTL_TX_COMMIT  = 1'b1
  } ctl_kind_e;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SHOW = 1'b1
  } tx_state_e;
endpackage

// File: rtl/cmsg_sdp_ram.sv
module cmsg_sdp_ram #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cmsg_rr_pick.sv
module cmsg_rr_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] pick,
  output logic          any
);
  logic [IW-1:0] idx;

  // Scan from the farthest candidate to the nearest so the queue right
  // after 'last' overrides all others.
  always_comb begin
    pick = '0;
    idx  = '0;
    any  = |req;
    for (int k = N; k >= 1; k--) begin
      idx = last + IW'(k);
      if (req[idx]) pick = idx;
    end
  end
endmodule

// File: rtl/cmsg_rx_ctrl.sv
module cmsg_rx_ctrl #(
  parameter int N   = 16,
  parameter int EPW = 4,
  parameter int PW  = 6,
  parameter int DW  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_valid,
  input  logic               rx_eop,
  input  logic [EPW-1:0]     rx_src,
  input  logic [DW-1:0]      rx_data,
  output logic               rx_ready,
  output logic               mem_we,
  output logic [EPW+PW-1:0]  mem_waddr,
  output logic [DW-1:0]      mem_wdata,
  input  logic               consume_en,
  input  logic [EPW-1:0]     ctl_q,
  input  logic [PW:0]        ctl_cnt,
  input  logic [EPW-1:0]     q_sel,
  output logic [PW-1:0]      sel_start,
  output logic [PW-1:0]      sel_end,
  output logic [PW:0]        sel_count
);
  localparam logic [PW:0] QD = (PW+1)'(1 << PW);

  // Pointers carry one extra bit so that full and empty differ.
  logic [PW:0] wr_q   [N];
  logic [PW:0] head_q [N];
  logic [PW:0] tail_q [N];

  logic [PW:0] used_src;
  logic [PW:0] avail_ctl;
  logic        acc;

  assign used_src  = wr_q[rx_src] - tail_q[rx_src];
  assign avail_ctl = head_q[ctl_q] - tail_q[ctl_q];
  assign rx_ready  = (used_src != QD);
  assign acc       = rx_valid && rx_ready;

  assign mem_we    = acc;
  assign mem_waddr = {rx_src, wr_q[rx_src][PW-1:0]};
  assign mem_wdata = rx_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        wr_q[i]   <= '0;
        head_q[i] <= '0;
        tail_q[i] <= '0;
      end
    end else begin
      if (acc) begin
        wr_q[rx_src] <= wr_q[rx_src] + 1'b1;
        if (rx_eop) head_q[rx_src] <= wr_q[rx_src] + 1'b1;
      end
      if (consume_en && (ctl_cnt <= avail_ctl))
        tail_q[ctl_q] <= tail_q[ctl_q] + ctl_cnt;
    end
  end

  assign sel_start = head_q[q_sel][PW-1:0];
  assign sel_end   = tail_q[q_sel][PW-1:0];
  assign sel_count = head_q[q_sel] - tail_q[q_sel];
endmodule

// File: rtl/cmsg_tx_ctrl.sv
module cmsg_tx_ctrl
  import cmsg_pkg::*;
#(
  parameter int N   = 16,
  parameter int EPW = 4,
  parameter int PW  = 6,
  parameter int DW  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit_en,
  input  logic [EPW-1:0]     ctl_q,
  input  logic [PW:0]        ctl_cnt,
  output logic               mem_re,
  output logic [EPW+PW-1:0]  mem_raddr,
  input  logic [DW-1:0]      mem_rdata,
  output logic               tx_valid,
  output logic               tx_sop,
  output logic               tx_eop,
  output logic [EPW-1:0]     tx_dst,
  output logic [DW-1:0]      tx_data,
  input  logic               tx_ready,
  input  logic [EPW-1:0]     q_sel,
  output logic [PW-1:0]      sel_start,
  output logic [PW:0]        sel_free,
  output logic               sel_busy
);
  localparam logic [PW:0] QD = (PW+1)'(1 << PW);

  logic [PW:0]    start_q [N];
  logic [PW:0]    end_q   [N];
  logic [PW:0]    plen    [N];
  logic [N-1:0]   pend;
  tx_state_e      state;
  logic [EPW-1:0] cur;
  logic [EPW-1:0] last;
  logic [PW:0]    idx;

  logic [EPW-1:0] pick;
  logic           any;
  logic [N-1:0]   req;
  logic [PW:0]    free_ctl;
  logic           commit_ok;
  logic           last_word;
  logic           fire;
  logic [PW:0]    nxt_off;

  assign req = (state == TX_IDLE) ? pend : '0;

  cmsg_rr_pick #(.N(N), .IW(EPW)) u_pick (
    .req  (req),
    .last (last),
    .pick (pick),
    .any  (any)
  );

  assign free_ctl  = QD - (start_q[ctl_q] - end_q[ctl_q]);
  assign commit_ok = commit_en && (ctl_cnt != '0) && !pend[ctl_q]
                     && (ctl_cnt <= free_ctl);
  assign last_word = (idx == plen[cur] - 1'b1);
  assign fire      = (state == TX_SHOW) && tx_ready;
  assign nxt_off   = end_q[cur] + idx + 1'b1;

  always_comb begin
    mem_re    = 1'b0;
    mem_raddr = '0;
    if (state == TX_IDLE && any) begin
      mem_re    = 1'b1;
      mem_raddr = {pick, end_q[pick][PW-1:0]};
    end else if (fire && !last_word) begin
      mem_re    = 1'b1;
      mem_raddr = {cur, nxt_off[PW-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        start_q[i] <= '0;
        end_q[i]   <= '0;
        plen[i]    <= '0;
      end
      pend  <= '0;
      state <= TX_IDLE;
      cur   <= '0;
      last  <= EPW'(N - 1);
      idx   <= '0;
    end else begin
      if (commit_ok) begin
        pend[ctl_q]    <= 1'b1;
        plen[ctl_q]    <= ctl_cnt;
        start_q[ctl_q] <= start_q[ctl_q] + ctl_cnt;
      end
      case (state)
        TX_IDLE: begin
          if (any) begin
            state <= TX_SHOW;
            cur   <= pick;
            idx   <= '0;
          end
        end
        TX_SHOW: begin
          if (fire) begin
            if (last_word) begin
              state      <= TX_IDLE;
              pend[cur]  <= 1'b0;
              end_q[cur] <= end_q[cur] + plen[cur];
              last       <= cur;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign tx_valid = (state == TX_SHOW);
  assign tx_sop   = (idx == '0);
  assign tx_eop   = last_word;
  assign tx_dst   = cur;
  assign tx_data  = mem_rdata;

  assign sel_start = start_q[q_sel][PW-1:0];
  assign sel_free  = QD - (start_q[q_sel] - end_q[q_sel]);
  assign sel_busy  = pend[q_sel];
endmodule

// File: rtl/cmsg_root.sv
module cmsg_root
  import cmsg_pkg::*;
#(
  parameter int N_EP   = 16,
  parameter int QDEPTH = 64,
  parameter int DW     = 16,
  localparam int EPW   = $clog2(N_EP),
  localparam int PW    = $clog2(QDEPTH),
  localparam int AW    = EPW + PW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_valid,
  input  logic           rx_eop,
  input  logic [EPW-1:0] rx_src,
  input  logic [DW-1:0]  rx_data,
  output logic           rx_ready,
  output logic           tx_valid,
  output logic           tx_sop,
  output logic           tx_eop,
  output logic [EPW-1:0] tx_dst,
  output logic [DW-1:0]  tx_data,
  input  logic           tx_ready,
  input  logic           usr_rd_en,
  input  logic [AW-1:0]  usr_rd_addr,
  output logic [DW-1:0]  usr_rd_data,
  input  logic           usr_wr_en,
  input  logic [AW-1:0]  usr_wr_addr,
  input  logic [DW-1:0]  usr_wr_data,
  input  logic           ctl_we,
  input  logic           ctl_kind,
  input  logic [EPW-1:0] ctl_q,
  input  logic [PW:0]    ctl_cnt,
  input  logic [EPW-1:0] stat_sel,
  output logic [PW-1:0]  stat_rx_start,
  output logic [PW-1:0]  stat_rx_end,
  output logic [PW:0]    stat_rx_count,
  output logic [PW-1:0]  stat_tx_start,
  output logic [PW:0]    stat_tx_free,
  output logic           stat_tx_busy
);
  localparam logic [PW:0] QD = (PW+1)'(QDEPTH);

  logic          rxm_we;
  logic [AW-1:0] rxm_waddr;
  logic [DW-1:0] rxm_wdata;
  logic          txm_re;
  logic [AW-1:0] txm_raddr;
  logic [DW-1:0] txm_rdata;
  logic          consume_en;
  logic          commit_en;

  logic [PW-1:0] rx_start_w, rx_end_w, tx_start_w;
  logic [PW:0]   rx_count_w, tx_free_w;
  logic          tx_busy_w;

  assign consume_en = ctl_we && (ctl_kind == CTL_RX_CONSUME);
  assign commit_en  = ctl_we && (ctl_kind == CTL_TX_COMMIT);

  // Receive storage: bus writes, user reads.
  cmsg_sdp_ram #(.DW(DW), .AW(AW)) u_rx_mem (
    .clk   (clk),
    .we    (rxm_we),
    .waddr (rxm_waddr),
    .wdata (rxm_wdata),
    .re    (usr_rd_en),
    .raddr (usr_rd_addr),
    .rdata (usr_rd_data)
  );

  // Transmit storage: user writes, sender reads.
  cmsg_sdp_ram #(.DW(DW), .AW(AW)) u_tx_mem (
    .clk   (clk),
    .we    (usr_wr_en),
    .waddr (usr_wr_addr),
    .wdata (usr_wr_data),
    .re    (txm_re),
    .raddr (txm_raddr),
    .rdata (txm_rdata)
  );

  cmsg_rx_ctrl #(.N(N_EP), .EPW(EPW), .PW(PW), .DW(DW)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_eop     (rx_eop),
    .rx_src     (rx_src),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .mem_we     (rxm_we),
    .mem_waddr  (rxm_waddr),
    .mem_wdata  (rxm_wdata),
    .consume_en (consume_en),
    .ctl_q      (ctl_q),
    .ctl_cnt    (ctl_cnt),
    .q_sel      (stat_sel),
    .sel_start  (rx_start_w),
    .sel_end    (rx_end_w),
    .sel_count  (rx_count_w)
  );

  cmsg_tx_ctrl #(.N(N_EP), .EPW(EPW), .PW(PW), .DW(DW)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .commit_en (commit_en),
    .ctl_q     (ctl_q),
    .ctl_cnt   (ctl_cnt),
    .mem_re    (txm_re),
    .mem_raddr (txm_raddr),
    .mem_rdata (txm_rdata),
    .tx_valid  (tx_valid),
    .tx_sop    (tx_sop),
    .tx_eop    (tx_eop),
    .tx_dst    (tx_dst),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .q_sel     (stat_sel),
    .sel_start (tx_start_w),
    .sel_free  (tx_free_w),
    .sel_busy  (tx_busy_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_rx_start <= '0;
      stat_rx_end   <= '0;
      stat_rx_count <= '0;
      stat_tx_start <= '0;
      stat_tx_free  <= QD;
      stat_tx_busy  <= 1'b0;
    end else begin
      stat_rx_start <= rx_start_w;
      stat_rx_end   <= rx_end_w;
      stat_rx_count <= rx_count_w;
      stat_tx_start <= tx_start_w;
      stat_tx_free  <= tx_free_w;
      stat_tx_busy  <= tx_busy_w;
    end
  end
endmodule

// File: rtl/cmsg_root_chk.sv
module cmsg_root_chk #(
  parameter int DW  = 16,
  parameter int EPW = 4,
  parameter int PW  = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic           tx_sop,
  input logic           tx_eop,
  input logic [EPW-1:0] tx_dst,
  input logic [DW-1:0]  tx_data,
  input logic [PW:0]    stat_rx_count,
  input logic [PW:0]    stat_tx_free
);
  localparam logic [PW:0] QD = (PW+1)'(1 << PW);

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !tx_valid);

  assert_rx_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    stat_rx_count <= QD);

  assert_tx_free_bound_R7: assert property (@(posedge clk) disable iff (rst)
    stat_tx_free <= QD);

  assert_packet_continues_R8: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready && !tx_eop |=> tx_valid && !tx_sop);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_dst)
                              && $stable(tx_sop) && $stable(tx_eop));
endmodule

bind cmsg_root cmsg_root_chk #(.DW(DW), .EPW(EPW), .PW(PW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_sop        (tx_sop),
  .tx_eop        (tx_eop),
  .tx_dst        (tx_dst),
  .tx_data       (tx_data),
  .stat_rx_count (stat_rx_count),
  .stat_tx_free  (stat_tx_free)
);

// File: tb/cmsg_root_tb.sv
`timescale 1ns/1ps
module cmsg_root_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 0, rx_eop = 0;
  logic [3:0]  rx_src = 0;
  logic [15:0] rx_data = 0;
  logic        rx_ready;
  logic        tx_valid, tx_sop, tx_eop;
  logic [3:0]  tx_dst;
  logic [15:0] tx_data;
  logic        tx_ready = 0;
  logic        usr_rd_en = 0;
  logic [9:0]  usr_rd_addr = 0;
  logic [15:0] usr_rd_data;
  logic        usr_wr_en = 0;
  logic [9:0]  usr_wr_addr = 0;
  logic [15:0] usr_wr_data = 0;
  logic        ctl_we = 0, ctl_kind = 0;
  logic [3:0]  ctl_q = 0;
  logic [6:0]  ctl_cnt = 0;
  logic [3:0]  stat_sel = 0;
  logic [5:0]  stat_rx_start, stat_rx_end, stat_tx_start;
  logic [6:0]  stat_rx_count, stat_tx_free;
  logic        stat_tx_busy;

  always #4 clk = ~clk;

  cmsg_root u_dut (.*);

  int checks = 0, errors = 0, cycles = 0;
  logic [15:0] rxm [1024];
  logic [15:0] txm [1024];
  int wrm [16];
  int cntm [16];
  int seqg = 0;
  logic [15:0] cap_data [128];
  logic [3:0]  cap_dst  [128];
  logic        cap_sop  [128];
  logic        cap_eop  [128];

  // {source[11:8], length[7:0]}
  localparam logic [11:0] RX_VEC [5] = '{
    {4'd3, 8'd4}, {4'd0, 8'd1}, {4'd15, 8'd6}, {4'd3, 8'd2}, {4'd8, 8'd3}
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rx_word(input int src, input bit eop);
    logic [15:0] d;
    d = 16'((src << 12) | (seqg & 12'hFFF));
    seqg++;
    rx_valid = 1; rx_src = 4'(src); rx_data = d; rx_eop = eop;
    #1;
    while (!rx_ready) tick();
    @(posedge clk); #1;
    rxm[src*64 + (wrm[src] % 64)] = d;
    wrm[src]++;
    if (eop) cntm[src] = wrm[src];
    rx_valid = 0; rx_eop = 0;
  endtask

  task automatic rx_packet(input int src, input int len);
    for (int n = 0; n < len; n++) rx_word(src, n == len - 1);
  endtask

  task automatic stat(input int q);
    stat_sel = 4'(q);
    tick();
  endtask

  task automatic ctl(input bit kind, input int q, input int cnt);
    ctl_we = 1; ctl_kind = kind; ctl_q = 4'(q); ctl_cnt = 7'(cnt);
    tick();
    ctl_we = 0;
  endtask

  task automatic usr_read(input int q, input int off);
    usr_rd_en = 1; usr_rd_addr = 10'(q*64 + off);
    tick();
    usr_rd_en = 0;
  endtask

  task automatic usr_write(input int q, input int off, input logic [15:0] d);
    usr_wr_en = 1; usr_wr_addr = 10'(q*64 + off); usr_wr_data = d;
    txm[q*64 + off] = d;
    tick();
    usr_wr_en = 0;
  endtask

  task automatic capture(input int n);
    int got = 0;
    int guard = 0;
    while (got < n && guard < 2000) begin
      if (tx_valid && tx_ready) begin
        cap_data[got] = tx_data; cap_dst[got] = tx_dst;
        cap_sop[got] = tx_sop;   cap_eop[got] = tx_eop;
        got++;
      end
      tick();
      guard++;
    end
    chk("R8 word count", got, n);
  endtask

  task automatic chk_packet(input int base, input int q, input int start, input int len);
    for (int i = 0; i < len; i++) begin
      chk("R11 dst order", cap_dst[base+i], q);
      chk("R8 data", cap_data[base+i], txm[q*64 + ((start + i) % 64)]);
      chk("R8 sop", cap_sop[base+i], i == 0);
      chk("R8 eop", cap_eop[base+i], i == len - 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin wrm[i] = 0; cntm[i] = 0; end
    repeat (4) tick();
    rst = 0;
    #1;
    // R1 reset state
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rx_ready", rx_ready, 1);
    stat(3);
    chk("R1 rx_count", stat_rx_count, 0);
    chk("R1 rx_start", stat_rx_start, 0);
    chk("R1 tx_free", stat_tx_free, 64);
    chk("R1 tx_busy", stat_tx_busy, 0);

    // Table of receive packets: R2 R3 R12
    for (int v = 0; v < 5; v++) begin
      int s, l;
      s = int'(RX_VEC[v][11:8]);
      l = int'(RX_VEC[v][7:0]);
      rx_packet(s, l);
      stat(s);
      chk("R3 rx_count", stat_rx_count, cntm[s]);
      chk("R3 rx_start", stat_rx_start, cntm[s] % 64);
    end
    for (int o = 0; o < 6; o++) begin
      usr_read(3, o);
      chk("R2 rx data q3", usr_rd_data, rxm[3*64 + o]);
    end
    usr_read(15, 5);
    chk("R2 rx data q15", usr_rd_data, rxm[15*64 + 5]);

    // R3 partial packet is not counted
    rx_word(9, 0);
    rx_word(9, 0);
    stat(9);
    chk("R3 partial count", stat_rx_count, 0);
    rx_word(9, 1);
    stat(9);
    chk("R3 completed count", stat_rx_count, 3);

    // R5 consume
    ctl(0, 3, 4);
    stat(3);
    chk("R5 rx_end", stat_rx_end, 4);
    chk("R5 rx_count", stat_rx_count, 2);
    ctl(0, 3, 3);
    stat(3);
    chk("R5 oversize ignored end", stat_rx_end, 4);
    chk("R5 oversize ignored count", stat_rx_count, 2);
    ctl(0, 3, 2);
    stat(3);
    chk("R5 drained", stat_rx_count, 0);

    // R4 full queue stalls
    for (int p = 0; p < 4; p++) rx_packet(5, 16);
    stat(5);
    chk("R4 full count", stat_rx_count, 64);
    rx_valid = 1; rx_src = 5; #1;
    chk("R4 ready low when full", rx_ready, 0);
    rx_src = 6; #1;
    chk("R4 other queue ready", rx_ready, 1);
    rx_valid = 0; rx_src = 5;
    ctl(0, 5, 16);
    #1;
    chk("R4 ready after consume", rx_ready, 1);
    // R6 wrap on receive
    rx_packet(5, 3);
    stat(5);
    chk("R6 rx wrap start", stat_rx_start, 3);
    chk("R6 rx wrap count", stat_rx_count, 51);
    usr_read(5, 0);
    chk("R6 rx wrapped word", usr_rd_data, rxm[5*64 + 0]);
    ctl(0, 5, 51);
    stat(5);
    chk("R6 rx end wrap", stat_rx_end, 3);

    // Transmit: stalled packet on q7
    for (int o = 0; o < 5; o++) usr_write(7, o, 16'h7100 + 16'(o));
    ctl(1, 7, 5);
    stat(7);
    chk("R7 tx_start", stat_tx_start, 5);
    chk("R7 tx_busy", stat_tx_busy, 1);
    chk("R10 free before send", stat_tx_free, 59);
    chk("R8 first valid", tx_valid, 1);
    chk("R8 first sop", tx_sop, 1);
    chk("R8 first dst", tx_dst, 7);
    chk("R8 first data", tx_data, txm[7*64]);
    // R7 rejected commits
    ctl(1, 7, 2);
    ctl(1, 4, 0);
    ctl(1, 4, 65);
    stat(7);
    chk("R7 busy commit ignored", stat_tx_start, 5);
    stat(4);
    chk("R7 zero/oversize ignored busy", stat_tx_busy, 0);
    chk("R7 zero/oversize ignored start", stat_tx_start, 0);
    for (int o = 0; o < 2; o++) usr_write(2, o, 16'h2200 + 16'(o));
    for (int o = 0; o < 3; o++) usr_write(9, o, 16'h9900 + 16'(o));
    ctl(1, 2, 2);
    ctl(1, 9, 3);
    // R9 held while stalled
    chk("R9 held valid", tx_valid, 1);
    chk("R9 held data", tx_data, txm[7*64]);
    chk("R9 held dst", tx_dst, 7);
    stat(7);
    chk("R10 still busy", stat_tx_busy, 1);
    // R11 round-robin: 7 then 9 then 2
    tx_ready = 1;
    capture(10);
    chk_packet(0, 7, 0, 5);
    chk_packet(5, 9, 0, 3);
    chk_packet(8, 2, 0, 2);
    stat(7);
    chk("R10 free restored", stat_tx_free, 64);
    chk("R10 busy cleared", stat_tx_busy, 0);

    // R6 transmit wrap on q2 (start is 2)
    for (int o = 2; o < 64; o++) usr_write(2, o, 16'h2000 + 16'(o));
    ctl(1, 2, 62);
    capture(62);
    chk_packet(0, 2, 2, 62);
    stat(2);
    chk("R6 tx start wrap", stat_tx_start, 0);
    for (int o = 0; o < 3; o++) usr_write(2, o, 16'h2A00 + 16'(o));
    ctl(1, 2, 3);
    capture(3);
    chk_packet(0, 2, 0, 3);
    stat(2);
    chk("R6 tx start after wrap", stat_tx_start, 3);
    chk("R10 free after wrap", stat_tx_free, 64);

    summary();
  end
endmodule